// File: doc/BRIEF.md
# Sampling Converter Serial Port Model

This block is a synthesizable stand-in for the digital side of a two-channel, 16-bit sampling converter. It runs from a fast system clock and oversamples three slow external pins: a convert strobe, a shift clock and a serial configuration input. It answers on a serial data output that has its own output-enable, which a pad ring or a bench turns into a tri-state line. No analog front end is modelled. The two channel codes arrive on parallel input ports, and the block latches the code that the current channel selection picks.

A rising convert strobe starts a conversion timer of fixed length in system cycles. When the timer runs out and the strobe is still high, the selected code is latched and the block sleeps. If the strobe drops before then, the conversion is abandoned and flagged. While the strobe is low the output is enabled and the result is shifted out most significant bit first. The first two bits that arrive on the serial input at the same time choose the channel set-up for the following conversion. A full transfer must take place before another conversion may begin.

Top module: `adc_port_model`

## Requirements
- R1: After reset, busy, asleep, aborted and data_valid are all 0, and the channel set-up is channel 0 against ground.
- R2: A rising convert strobe, when a conversion is allowed, raises busy for exactly CONV_CYCLES system cycles. A conversion that completes sets data_valid.
- R3: If the strobe is still high when the timer ends, asleep goes to 1 and stays 1 until the strobe falls. sdo_oe is 0 whenever the strobe has been high long enough to pass the synchronizer.
- R4: A falling strobe while busy aborts the conversion. aborted goes to 1, data_valid stays 0, and the word then shifted out is all zeros.
- R5: After any conversion, a rising strobe is ignored (busy stays 0) until a transfer of at least 16 shift-clock rising edges with the strobe low has completed.
- R6: When the strobe falls, bit 15 of the result appears on sdo_o. Each falling shift-clock edge advances to the next lower bit, so the host samples B15 to B0 on its rising edges.
- R7: After the sixteenth bit, further shift clocks with the strobe low give 0 on sdo_o.
- R8: The serial input bit on the first rising shift-clock edge after the strobe falls is the single-ended flag. The bit on the second rising edge is the odd/sign flag. Later bits in that transfer have no effect. The captured set-up applies to the next conversion.
- R9: Selection, as {single-ended, odd}: 10 gives ch0_code, 11 gives ch1_code, 00 gives ch0_code minus ch1_code, and 01 gives ch1_code minus ch0_code. A negative difference gives code 0. Codes are straight binary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_pin | input | 1 | External convert strobe, asynchronous |
| sck_pin | input | 1 | External shift clock, asynchronous |
| sdi_pin | input | 1 | External serial configuration input |
| ch0_code | input | 16 | Code presented for channel 0 |
| ch1_code | input | 16 | Code presented for channel 1 |
| sdo_o | output | 1 | Serial result data |
| sdo_oe | output | 1 | Output enable for sdo_o, high while the strobe is low |
| busy | output | 1 | Conversion timer running |
| asleep | output | 1 | Conversion complete, strobe still high |
| aborted | output | 1 | Last conversion was cut short |
| data_valid | output | 1 | Latched result is from a completed conversion |

## Verification
The assertions check on every cycle that sleep never coexists with a running timer, that sleep implies a valid result, that an abort never leaves a valid result, that busy never outlasts the conversion window, and that the output stays disabled under a settled high strobe. Only the bench scenarios can show the bit order and content of shifted words, the zeros after the sixteenth bit, the mux arithmetic with its clamp, the delayed effect of the set-up bits, and the refusal of a new conversion after an abort until a full transfer.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef struct packed {
    logic single;
    logic odd;
  } mux_cfg_t;

  localparam mux_cfg_t CFG_DEFAULT = '{single: 1'b1, odd: 1'b0};
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= '0;
      end else if (g == 0) begin
        stage_q[g] <= pin_i;
      end else begin
        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign lvl_o = stage_q[STAGES-1];
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 185
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cancel_i,
  output logic busy_o,
  output logic done_o,
  output logic abort_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_o  <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      if (busy_q) begin
        if (cancel_i) begin
          busy_q  <= 1'b0;
          abort_o <= 1'b1;
        end else if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(CONV_CYCLES - 1);
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/adc_mux_select.sv
module adc_mux_select #(
  parameter int DW = 16
) (
  input  adc_port_pkg::mux_cfg_t cfg_i,
  input  logic [DW-1:0]          ch0_i,
  input  logic [DW-1:0]          ch1_i,
  output logic [DW-1:0]          code_o
);
  logic [DW:0] diff;

  always_comb begin
    diff = '0;
    if (cfg_i.single) begin
      code_o = cfg_i.odd ? ch1_i : ch0_i;
    end else begin
      if (cfg_i.odd) diff = {1'b0, ch1_i} - {1'b0, ch0_i};
      else           diff = {1'b0, ch0_i} - {1'b0, ch1_i};
      code_o = diff[DW] ? '0 : diff[DW-1:0];
    end
  end
endmodule

// File: rtl/adc_shifter.sv
module adc_shifter #(
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   conv_lvl_i,
  input  logic                   conv_fall_i,
  input  logic                   sck_rise_i,
  input  logic                   sck_fall_i,
  input  logic                   sdi_lvl_i,
  input  logic [DW-1:0]          load_word_i,
  output logic                   sdo_bit_o,
  output adc_port_pkg::mux_cfg_t cfg_o,
  output logic                   xfer_done_o
);
  localparam int BW = $clog2(DW + 1);

  logic [DW-1:0] shreg_q;
  logic [BW-1:0] bitcnt_q;
  logic          first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q     <= '0;
      bitcnt_q    <= '0;
      first_q     <= 1'b1;
      cfg_o       <= adc_port_pkg::CFG_DEFAULT;
      xfer_done_o <= 1'b0;
    end else begin
      xfer_done_o <= 1'b0;
      if (conv_fall_i) begin
        shreg_q  <= load_word_i;
        bitcnt_q <= '0;
      end else if (!conv_lvl_i) begin
        if (sck_fall_i) shreg_q <= {shreg_q[DW-2:0], 1'b0};
        if (sck_rise_i && (bitcnt_q != BW'(DW))) begin
          bitcnt_q <= bitcnt_q + 1'b1;
          if (bitcnt_q == '0) first_q <= sdi_lvl_i;
          if (bitcnt_q == BW'(1)) cfg_o <= '{single: first_q, odd: sdi_lvl_i};
          if (bitcnt_q == BW'(DW - 1)) xfer_done_o <= 1'b1;
        end
      end
    end
  end

  assign sdo_bit_o = shreg_q[DW-1];
endmodule

// File: rtl/adc_port_model.sv
module adc_port_model #(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CONV_CYCLES = 185
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_pin,
  input  logic          sck_pin,
  input  logic          sdi_pin,
  input  logic [DW-1:0] ch0_code,
  input  logic [DW-1:0] ch1_code,
  output logic          sdo_o,
  output logic          sdo_oe,
  output logic          busy,
  output logic          asleep,
  output logic          aborted,
  output logic          data_valid
);
  import adc_port_pkg::*;

  logic [2:0] pins_lvl;
  logic       conv_lvl, sck_lvl, sdi_lvl;
  logic       conv_prev_q, sck_prev_q;
  logic       conv_rise, conv_fall, sck_rise, sck_fall;
  logic       armed_q, start;
  logic       tmr_done, tmr_abort;
  logic       shift_bit, xfer_done;
  mux_cfg_t   cfg_next, cfg_active_q;
  logic [DW-1:0] mux_code, result_q, load_word;

  adc_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({conv_pin, sck_pin, sdi_pin}),
    .lvl_o (pins_lvl)
  );

  assign {conv_lvl, sck_lvl, sdi_lvl} = pins_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_prev_q <= 1'b0;
      sck_prev_q  <= 1'b0;
    end else begin
      conv_prev_q <= conv_lvl;
      sck_prev_q  <= sck_lvl;
    end
  end

  assign conv_rise = conv_lvl & ~conv_prev_q;
  assign conv_fall = ~conv_lvl & conv_prev_q;
  assign sck_rise  = sck_lvl & ~sck_prev_q;
  assign sck_fall  = ~sck_lvl & sck_prev_q;
  assign start     = conv_rise & armed_q & ~busy;

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .cancel_i (conv_fall),
    .busy_o   (busy),
    .done_o   (tmr_done),
    .abort_o  (tmr_abort)
  );

  adc_mux_select #(.DW(DW)) u_mux (
    .cfg_i  (cfg_active_q),
    .ch0_i  (ch0_code),
    .ch1_i  (ch1_code),
    .code_o (mux_code)
  );

  assign load_word = data_valid ? result_q : '0;

  adc_shifter #(.DW(DW)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_lvl_i  (conv_lvl),
    .conv_fall_i (conv_fall),
    .sck_rise_i  (sck_rise),
    .sck_fall_i  (sck_fall),
    .sdi_lvl_i   (sdi_lvl),
    .load_word_i (load_word),
    .sdo_bit_o   (shift_bit),
    .cfg_o       (cfg_next),
    .xfer_done_o (xfer_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q      <= 1'b1;
      cfg_active_q <= CFG_DEFAULT;
      result_q     <= '0;
      data_valid   <= 1'b0;
      asleep       <= 1'b0;
      aborted      <= 1'b0;
    end else begin
      if (start) begin
        armed_q      <= 1'b0;
        cfg_active_q <= cfg_next;
        data_valid   <= 1'b0;
        aborted      <= 1'b0;
      end else if (xfer_done) begin
        armed_q <= 1'b1;
      end
      if (tmr_done) begin
        result_q   <= mux_code;
        data_valid <= 1'b1;
        asleep     <= conv_lvl;
      end else if (conv_fall) begin
        asleep <= 1'b0;
      end
      if (tmr_abort) aborted <= 1'b1;
    end
  end

  assign sdo_oe = ~conv_lvl;
  assign sdo_o  = sdo_oe & shift_bit;
endmodule

// File: rtl/adc_port_checker.sv
module adc_port_checker #(
  parameter int CONV_CYCLES = 185
) (
  input logic clk,
  input logic rst_n,
  input logic conv_pin,
  input logic sdo_oe,
  input logic busy,
  input logic asleep,
  input logic aborted,
  input logic data_valid
);
  localparam int RW = $clog2(CONV_CYCLES + 2) + 1;
  logic [RW-1:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run_q <= '0;
    else if (busy) busy_run_q <= busy_run_q + 1'b1;
    else           busy_run_q <= '0;
  end

  p_busy_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run_q <= RW'(CONV_CYCLES));

  p_no_busy_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && asleep));

  p_sleep_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> data_valid);

  p_hiz_high_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_pin && $past(conv_pin) && $past(conv_pin, 2)) |-> !sdo_oe);

  p_abort_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> !data_valid);
endmodule

bind adc_port_model adc_port_checker #(.CONV_CYCLES(CONV_CYCLES)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_pin   (conv_pin),
  .sdo_oe     (sdo_oe),
  .busy       (busy),
  .asleep     (asleep),
  .aborted    (aborted),
  .data_valid (data_valid)
);

// File: tb/test_adc_port_model.sv
module test_adc_port_model;
  localparam int DW   = 16;
  localparam int CONV = 185;
  localparam int HALF = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_pin = 1'b0, sck_pin = 1'b0, sdi_pin = 1'b0;
  logic [DW-1:0] ch0_code = '0, ch1_code = '0;
  logic          sdo_o, sdo_oe, busy, asleep, aborted, data_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] got_word;
  string         got_tag;
  event          word_ev;

  always #10 clk = ~clk;

  adc_port_model #(.DW(DW), .SYNC_STAGES(2), .CONV_CYCLES(CONV)) i_adc_port_model (
    .clk(clk), .rst_n(rst_n), .conv_pin(conv_pin), .sck_pin(sck_pin), .sdi_pin(sdi_pin),
    .ch0_code(ch0_code), .ch1_code(ch1_code), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .busy(busy), .asleep(asleep), .aborted(aborted), .data_valid(data_valid)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares each shifted word against the scoreboard queue (R6).
  initial begin
    forever begin
      @(word_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, {"R6 unexpected word ", got_tag}, {16'h0, got_word}, 32'h0);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        check(got_word === e, {"R6/R9 word ", got_tag}, {16'h0, got_word}, {16'h0, e});
      end
    end
  end

  // Full conversion with strobe held high (R2, R3).
  task automatic convert(input logic [DW-1:0] expect_word, input string tag);
    conv_pin = 1'b1;
    tick(20);
    check(busy === 1'b1, {"R2 busy mid ", tag}, {31'h0, busy}, 32'h1);
    check(sdo_oe === 1'b0, {"R3 oe off ", tag}, {31'h0, sdo_oe}, 32'h0);
    tick(CONV);
    check(busy === 1'b0 && data_valid === 1'b1, {"R2 done ", tag}, {30'h0, busy, data_valid}, 32'h1);
    check(asleep === 1'b1, {"R3 asleep ", tag}, {31'h0, asleep}, 32'h1);
    exp_q.push_back(expect_word);
  endtask

  // Transfer: first two SDI bits carry the set-up, the rest are ones (R8).
  task automatic transfer(input bit sgl, input bit odd, input int nbits, input string tag);
    logic [DW-1:0] w = '0;
    conv_pin = 1'b0;
    tick(8);
    check(sdo_oe === 1'b1 && asleep === 1'b0, {"R3 oe on, sleep left ", tag}, {30'h0, sdo_oe, asleep}, 32'h2);
    for (int i = 0; i < nbits; i++) begin
      sdi_pin = (i == 0) ? sgl : (i == 1) ? odd : 1'b1;
      tick(HALF);
      if (i < DW) w = {w[DW-2:0], sdo_o};
      else check(sdo_o === 1'b0, {"R7 trailing zero ", tag}, {31'h0, sdo_o}, 32'h0);
      sck_pin = 1'b1;
      tick(HALF);
      sck_pin = 1'b0;
      tick(HALF);
    end
    got_word = w;
    got_tag  = tag;
    -> word_ev;
    tick(2);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    check({busy, asleep, aborted, data_valid} === 4'b0, "R1 flags clear", {28'h0, busy, asleep, aborted, data_valid}, 32'h0);

    // R1 default set-up CH0 single-ended; R9 code 10
    ch0_code = 16'h1234; ch1_code = 16'hABCD;
    convert(16'h1234, "c1");
    transfer(1'b1, 1'b1, DW, "t1");          // R8 selects CH1 next
    convert(16'hABCD, "c2");                 // R9 code 11
    ch0_code = 16'h9000; ch1_code = 16'h1000;
    transfer(1'b0, 1'b0, DW, "t2");
    convert(16'h8000, "c3");                 // R9 code 00
    transfer(1'b0, 1'b1, DW + 5, "t3");      // R7 extra clocks
    convert(16'h0000, "c4");                 // R9 code 01 clamps
    ch0_code = 16'h0000; ch1_code = 16'hFFFF;
    transfer(1'b0, 1'b1, DW, "t4");
    convert(16'hFFFF, "c5");                 // R9 full scale
    transfer(1'b1, 1'b0, DW, "t5");

    // R4 abort
    ch0_code = 16'h00FF;
    conv_pin = 1'b1;
    tick(30);
    conv_pin = 1'b0;
    tick(8);
    check(aborted === 1'b1 && data_valid === 1'b0, "R4 abort flags", {30'h0, aborted, data_valid}, 32'h2);
    check(busy === 1'b0, "R4 timer stopped", {31'h0, busy}, 32'h0);
    // R5 rise before a full transfer is ignored
    conv_pin = 1'b1;
    tick(20);
    check(busy === 1'b0, "R5 start refused", {31'h0, busy}, 32'h1 ^ 32'h1);
    exp_q.push_back(16'h0000);               // R4 invalid word reads as zeros
    transfer(1'b1, 1'b0, DW, "t6");
    convert(16'h00FF, "c6");                 // R5 allowed again
    transfer(1'b1, 1'b0, DW, "t7");
    tick(10);
    check(exp_q.size() == 0, "R6 all words seen", exp_q.size(), 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule